// File: doc/BRIEF.md
# Temperature-Derated Refresh Scheduler

This block paces refresh requests for a DRAM controller. A down-counter marks out evenly spaced intervals. Their length in cycles comes from three parameters: the retention window, the number of refresh rows that must be covered inside that window, and the clock period in picoseconds. At every interval boundary the block adds one to a count of owed refreshes. The request output stays high as long as that count is nonzero. The command engine pulses an acknowledge for each refresh it issues, and each pulse removes one from the count. This lets the engine postpone a few refreshes while it is busy and catch up later.

A case-temperature flag from outside selects the hot regime. In that regime the retention window is halved, so the interval is halved too. The flag is sampled only at an interval boundary, so a count already in progress always runs to its end at the old length. The owed count stops at eight, and an urgent output reports that limit. A separate flag reports that the case temperature is beyond the supported range, and the block registers it onto an error output.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, req_o, urgent_o, err_o and hot_mode_o are 0, and owed_o is 0.
- R2: With hot mode off, an interval lasts NORM = WINDOW_NS*1000/(ROWS*CLK_PS) cycles. The first boundary falls on the NORM-th rising edge after reset is released, and owed_o rises by one at that edge.
- R3: With hot mode on, an interval lasts NORM/2 cycles.
- R4: hot_i is sampled only on the edge that ends an interval. hot_mode_o shows the regime of the interval now running, and the length of the next interval follows that sampled value.
- R5: owed_o counts boundaries not yet acknowledged and never exceeds OWED_MAX (8). A boundary that arrives at the limit is dropped.
- R6: req_o is high exactly while owed_o is nonzero.
- R7: An ack_i pulse sampled while owed_o is nonzero lowers it by one. An ack while owed_o is zero has no effect. An ack on a boundary edge leaves owed_o unchanged.
- R8: urgent_o is high exactly while owed_o equals OWED_MAX.
- R9: err_o equals the over_range_i value sampled at the previous rising edge.
- R10: The interval arithmetic holds for a 1250 ps clock and for a 1500 ps clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hot_i | input | 1 | Case temperature in the hot band |
| over_range_i | input | 1 | Case temperature above the supported range |
| ack_i | input | 1 | One-cycle pulse per refresh issued |
| req_o | output | 1 | Refresh owed |
| urgent_o | output | 1 | Owed count at its limit |
| owed_o | output | $clog2(OWED_MAX+1) | Number of refreshes owed |
| hot_mode_o | output | 1 | Regime of the current interval |
| err_o | output | 1 | Registered over-range flag |

## Verification
Every output is a register, so any result is due at the rising edge that samples its cause. The owed count moves on the boundary edge and the ack edge, the regime changes on the boundary edge, and the error follows over_range_i one edge later. The bench drives inputs on the falling edge. At each rising edge it advances its own arithmetic interval model for two clock periods, and it compares every output on the next falling edge. This places each check exactly one edge after its stimulus and never at an edge. Explicit checks at edges NORM, NORM+NORM/2 and their neighbours pin down the interval lengths.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int     CLK_PS    = 1250,
  parameter longint WINDOW_NS = 64_000_000,
  parameter int     ROWS      = 8192,
  parameter int     OWED_MAX  = 8,
  localparam int    OW        = $clog2(OWED_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hot_i,
  input  logic          over_range_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          urgent_o,
  output logic [OW-1:0] owed_o,
  output logic          hot_mode_o,
  output logic          err_o
);
  localparam longint NORM = (WINDOW_NS * 1000) / (longint'(ROWS) * CLK_PS);
  localparam longint HOT  = NORM / 2;
  localparam int     CW   = $clog2(NORM) + 1;

  logic [CW-1:0] cnt;
  logic [OW-1:0] owed;
  logic [OW:0]   sum;
  logic          hot_q, err_q;
  wire           tick = (cnt == '0);

  always_comb begin
    sum = {1'b0, owed} + (OW+1)'(tick);
    if (ack_i && owed != '0) sum = sum - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= CW'(NORM - 1);
      hot_q <= 1'b0;
      owed  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= over_range_i;
      owed  <= (sum > (OW+1)'(OWED_MAX)) ? OW'(OWED_MAX) : sum[OW-1:0];
      if (tick) begin
        cnt   <= hot_i ? CW'(HOT - 1) : CW'(NORM - 1);
        hot_q <= hot_i;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign owed_o     = owed;
  assign req_o      = (owed != '0);
  assign urgent_o   = (owed == OW'(OWED_MAX));
  assign hot_mode_o = hot_q;
  assign err_o      = err_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int OWED_MAX = 8,
  parameter int OW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hot_i,
  input logic          over_range_i,
  input logic          ack_i,
  input logic          req_o,
  input logic          urgent_o,
  input logic [OW-1:0] owed_o,
  input logic          hot_mode_o,
  input logic          err_o
);
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    owed_o <= OW'(OWED_MAX));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((OW+1)'(owed_o) <= (OW+1)'($past(owed_o)) + 1'b1) &&
             ((OW+1)'(owed_o) + 1'b1 >= (OW+1)'($past(owed_o))));

  a_r7_ack_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && owed_o == '0) |=> owed_o <= OW'(1));

  a_r8_urgent_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> req_o);

  a_r6_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !urgent_o) |-> owed_o == '0);

  a_r4_mode_from_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hot_mode_o == $past(hot_mode_o)) || (hot_mode_o == $past(hot_i)));

  a_r9_err_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_o == $past(over_range_i));
endmodule

bind refresh_sched refresh_sched_chk #(.OWED_MAX(OWED_MAX), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .over_range_i(over_range_i),
  .ack_i(ack_i), .req_o(req_o), .urgent_o(urgent_o), .owed_o(owed_o),
  .hot_mode_o(hot_mode_o), .err_o(err_o)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
  localparam int MAXO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot = 1'b0, ovr = 1'b0, ack = 1'b0;
  logic req [2], urg [2], hm [2], er [2];
  logic [3:0] ow [2];

  int n_run = 0, n_fail = 0;
  int len_n [2] = '{8, 10};
  int since [2], len [2], owed_m [2];
  logic mode_m [2], err_m [2];

  always #2.5 clk = ~clk;

  // 81920 ns window, 8192 rows, 1250 ps -> 8 cycles (hot 4)
  refresh_sched #(.CLK_PS(1250), .WINDOW_NS(81920), .ROWS(8192), .OWED_MAX(MAXO)) dut_i (
    .clk(clk), .rst_n(rst_n), .hot_i(hot), .over_range_i(ovr), .ack_i(ack),
    .req_o(req[0]), .urgent_o(urg[0]), .owed_o(ow[0]), .hot_mode_o(hm[0]), .err_o(er[0]));

  // 122880 ns window, 8192 rows, 1500 ps -> 10 cycles (hot 5)
  refresh_sched #(.CLK_PS(1500), .WINDOW_NS(122880), .ROWS(8192), .OWED_MAX(MAXO)) dut2_i (
    .clk(clk), .rst_n(rst_n), .hot_i(hot), .over_range_i(ovr), .ack_i(ack),
    .req_o(req[1]), .urgent_o(urg[1]), .owed_o(ow[1]), .hot_mode_o(hm[1]), .err_o(er[1]));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      since[i] = 0; len[i] = len_n[i]; owed_m[i] = 0; mode_m[i] = 1'b0; err_m[i] = 1'b0;
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      chk(i ? "R5/R7 owed dut2" : "R5/R7 owed dut", int'(ow[i]), owed_m[i]);
      chk("R6 req", int'(req[i]), int'(owed_m[i] != 0));
      chk("R8 urgent", int'(urg[i]), int'(owed_m[i] == MAXO));
      chk("R4 mode", int'(hm[i]), int'(mode_m[i]));
      chk("R9 err", int'(er[i]), int'(err_m[i]));
    end
  endtask

  task automatic step(input logic h, input logic o, input logic a);
    hot = h; ovr = o; ack = a;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      int t, ae;
      ae = (a && owed_m[i] > 0) ? 1 : 0;
      since[i]++;
      t = (since[i] == len[i]) ? 1 : 0;
      if (t == 1) begin
        since[i] = 0;
        len[i] = h ? len_n[i] / 2 : len_n[i];
        mode_m[i] = h;
      end
      owed_m[i] = owed_m[i] + t - ae;
      if (owed_m[i] > MAXO) owed_m[i] = MAXO;
      err_m[i] = o;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hot = 0; ovr = 0; ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 req in reset", int'(req[0] | req[1]), 0);
    chk("R1 owed in reset", int'(ow[0] | ow[1]), 0);
    chk("R1 urgent/mode/err in reset", int'(urg[0] | urg[1] | hm[0] | hm[1] | er[0] | er[1]), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(0, 0, 0);
    chk("R1 owed after reset", int'(ow[0]), 0);
    repeat (6) step(0, 0, 0);
    chk("R2 no boundary before edge 8", int'(ow[0]), 0);
    step(0, 0, 0);
    chk("R2 boundary at edge 8", int'(ow[0]), 1);
    step(0, 0, 0);
    chk("R10 dut2 no boundary at edge 9", int'(ow[1]), 0);
    step(0, 0, 0);
    chk("R10 dut2 boundary at edge 10", int'(ow[1]), 1);
    repeat (90) step(0, 0, 0);
    chk("R5 saturated", int'(ow[0]), MAXO);
    chk("R8 urgent at limit", int'(urg[0]), 1);
    for (int k = 0; k < 24; k++) step(0, 0, k % 2 == 0);
    repeat (4) step(0, 0, 1);
    step(0, 0, 1);
    chk("R7 ack at zero ignored", int'(ow[0]), 0);

    do_reset();
    repeat (3) step(0, 0, 0);
    step(1, 0, 0);
    chk("R4 mid-interval flag not taken", int'(hm[0]), 0);
    repeat (4) step(1, 0, 0);
    chk("R4 mode at boundary", int'(hm[0]), 1);
    repeat (4) step(1, 0, 0);
    chk("R3 hot interval 4", int'(ow[0]), 2);
    repeat (3) step(1, 0, 0);
    chk("R3 dut2 hot interval 5", int'(ow[1]), 2);
    for (int k = 0; k < 6; k++) step(1, k % 2, 0);
    chk("R9 err follows", int'(er[0]), 1);

    for (int k = 0; k < 600; k++)
      step(((k / 37) % 2) == 1, (k % 5) == 0, (k % 3) == 0 || (k / 150) == 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule